// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the combinational arithmetic and logic unit of a two-operand register machine. Each cycle it takes a destination operand, a source operand (a register value or an immediate, the unit does not care which), the current status flags and an operation select. It returns the result byte and the next value of the six arithmetic status flags. The carry input of the carry-using operations is bit 0 of the incoming flag vector.

Every operation owns a fixed subset of the flags. Flags outside that subset pass through unchanged, so the surrounding datapath can write the whole flag vector back on every instruction. Compare operations compute flags only and hand back the destination operand as the result. The subtract-with-carry and compare-with-carry operations keep the zero flag sticky, so that multi-byte comparisons chain across bytes.

Top module: `alu8`

## Requirements
- R1: The flag vector is 6 bits: bit0 C (carry), bit1 Z (zero), bit2 N (negative), bit3 V (overflow), bit4 S (sign), bit5 H (half carry). The carry in is `flags_in[0]`. Operation codes 19 to 31 return the destination operand and leave all flags unchanged.
- R2: Add (code 0) and add-with-carry (code 1) return dst+src (+C for code 1) and update Z, C, N, V and H. C is the carry out of bit 7, H is the carry out of bit 3 and V is signed overflow.
- R3: Subtract (code 2) and subtract-with-carry (code 3) return dst-src (-C for code 3) and update Z, C, N, V and H. C is the borrow out of bit 7 and H is the borrow into bit 4. For code 3, Z is set only if the result is zero and Z was already set.
- R4: Compare (code 4) and compare-with-carry (code 5) set the flags exactly as codes 2 and 3 do, including the sticky Z of code 5. The result output equals the destination operand.
- R5: AND (6), OR (7) and XOR (8) update only Z, N and V, with V forced to 0. C and H are unchanged.
- R6: Ones' complement (code 9) returns 0xFF-dst and updates Z, C, N and V, with C forced to 1 and V forced to 0.
- R7: Twos' complement (code 10) returns 0x00-dst and updates Z, C, N, V and H as a subtraction from zero would.
- R8: Increment (11) and decrement (12) update Z, N and V and never change C or H. V is set exactly when the operand was 0x7F for increment or 0x80 for decrement.
- R9: Shift left (13), shift right (14), rotate left through carry (15) and rotate right through carry (16) update Z, C, N and V. The rotates shift the old C into the vacated bit. C receives the bit shifted out. V equals N XOR the new C. H is unchanged.
- R10: Arithmetic shift right (17) shifts right, keeps bit 7 and updates Z, C, N and V as in R9.
- R11: Nibble swap (18) exchanges bits 7..4 with bits 3..0 and changes no flag.
- R12: Whenever an operation updates N or V, S becomes N XOR V. Otherwise S is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code |
| dst_a | input | 8 | Destination operand |
| src_b | input | 8 | Source operand (register or immediate) |
| flags_in | input | 6 | Current status flags; bit0 is the carry in |
| res | output | 8 | Result byte |
| flags_out | output | 6 | Next status flags |

## Verification
The bench goes after the overflow boundaries: 0x7F+1, 0x80-1, and negation of 0x80 and of 0x00. A design that takes V from the carry, or C from a bit, fails on these. It also targets the nibble boundaries that set H, where a design that takes the half carry from the wrong bit or inverts the borrow shows a wrong H. It runs chained SBC/CPC bytes with Z both set and clear on entry, so that a plain zero test is caught when it sets Z after an earlier nonzero byte. Finally, it drives every code, including the unused codes, with random operands and both carry states, so that a flag leaking into an operation's untouched subset, such as C moving on increment, appears at once.

// File: rtl/alu8.sv
module alu8 (
  input  logic [4:0] op_sel,
  input  logic [7:0] dst_a,
  input  logic [7:0] src_b,
  input  logic [5:0] flags_in,
  output logic [7:0] res,
  output logic [5:0] flags_out
);
  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_CP  = 5'd4,  OP_CPC = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7;
  localparam logic [4:0] OP_XOR = 5'd8,  OP_COM = 5'd9,  OP_NEG = 5'd10, OP_INC = 5'd11;
  localparam logic [4:0] OP_DEC = 5'd12, OP_LSL = 5'd13, OP_LSR = 5'd14, OP_ROL = 5'd15;
  localparam logic [4:0] OP_ROR = 5'd16, OP_ASR = 5'd17, OP_SWP = 5'd18;
  localparam int FC = 0, FZ = 1, FN = 2, FV = 3, FS = 4, FH = 5;

  logic       cin;
  logic [7:0] add_r, sa, sb, sub_r, val;
  logic       add_co, add_h, add_v, sub_c, sub_h, sub_v, sci;
  logic       upd, sticky_z;
  logic [5:0] f;

  assign cin = flags_in[FC];

  assign {add_co, add_r} = {1'b0, dst_a} + {1'b0, src_b} + {8'd0, (op_sel == OP_ADC) & cin};
  assign add_h = (dst_a[3] & src_b[3]) | (src_b[3] & ~add_r[3]) | (~add_r[3] & dst_a[3]);
  assign add_v = (dst_a[7] & src_b[7] & ~add_r[7]) | (~dst_a[7] & ~src_b[7] & add_r[7]);

  assign sa  = (op_sel == OP_NEG) ? 8'h00 : dst_a;
  assign sb  = (op_sel == OP_NEG) ? dst_a : src_b;
  assign sci = ((op_sel == OP_SBC) | (op_sel == OP_CPC)) & cin;
  assign sub_r = sa - sb - {7'd0, sci};
  assign sub_c = (~sa[7] & sb[7]) | (sb[7] & sub_r[7]) | (sub_r[7] & ~sa[7]);
  assign sub_h = (~sa[3] & sb[3]) | (sb[3] & sub_r[3]) | (sub_r[3] & ~sa[3]);
  assign sub_v = (sa[7] & ~sb[7] & ~sub_r[7]) | (~sa[7] & sb[7] & sub_r[7]);
  assign sticky_z = (op_sel == OP_SBC) | (op_sel == OP_CPC);

  always_comb begin
    val = dst_a;
    f   = flags_in;
    upd = 1'b1;
    unique case (op_sel)
      OP_ADD, OP_ADC: begin
        val = add_r; f[FC] = add_co; f[FH] = add_h; f[FV] = add_v;
      end
      OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
        val = sub_r; f[FC] = sub_c; f[FH] = sub_h; f[FV] = sub_v;
      end
      OP_AND: begin val = dst_a & src_b; f[FV] = 1'b0; end
      OP_OR:  begin val = dst_a | src_b; f[FV] = 1'b0; end
      OP_XOR: begin val = dst_a ^ src_b; f[FV] = 1'b0; end
      OP_COM: begin val = ~dst_a; f[FC] = 1'b1; f[FV] = 1'b0; end
      OP_INC: begin val = dst_a + 8'd1; f[FV] = (dst_a == 8'h7F); end
      OP_DEC: begin val = dst_a - 8'd1; f[FV] = (dst_a == 8'h80); end
      OP_LSL: begin val = {dst_a[6:0], 1'b0};     f[FC] = dst_a[7]; f[FV] = dst_a[6] ^ dst_a[7]; end
      OP_ROL: begin val = {dst_a[6:0], cin};      f[FC] = dst_a[7]; f[FV] = dst_a[6] ^ dst_a[7]; end
      OP_LSR: begin val = {1'b0, dst_a[7:1]};     f[FC] = dst_a[0]; f[FV] = dst_a[0]; end
      OP_ROR: begin val = {cin, dst_a[7:1]};      f[FC] = dst_a[0]; f[FV] = cin ^ dst_a[0]; end
      OP_ASR: begin val = {dst_a[7], dst_a[7:1]}; f[FC] = dst_a[0]; f[FV] = dst_a[7] ^ dst_a[0]; end
      OP_SWP: begin val = {dst_a[3:0], dst_a[7:4]}; upd = 1'b0; end
      default: upd = 1'b0;
    endcase
    if (upd) begin
      f[FN] = val[7];
      f[FZ] = (val == 8'h00) & (~sticky_z | flags_in[FZ]);
      f[FS] = val[7] ^ f[FV];
    end
  end

  assign res       = ((op_sel == OP_CP) | (op_sel == OP_CPC)) ? dst_a : val;
  assign flags_out = f;
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk (
  input logic [4:0] op_sel,
  input logic [7:0] dst_a,
  input logic [7:0] src_b,
  input logic [5:0] flags_in,
  input logic [7:0] res,
  input logic [5:0] flags_out
);
  always_comb begin
    if (op_sel > 5'd18) begin
      AST_UNUSED_PASS: assert (res == dst_a && flags_out == flags_in) else $error("unused op"); // R1
    end
    if (op_sel == 5'd3 || op_sel == 5'd5) begin
      AST_STICKY_Z: assert (flags_in[1] || !flags_out[1]) else $error("Z chain"); // R3
    end
    if (op_sel == 5'd4 || op_sel == 5'd5) begin
      AST_CMP_NOWRITE: assert (res == dst_a) else $error("compare wrote"); // R4
    end
    if (op_sel >= 5'd6 && op_sel <= 5'd8) begin
      AST_LOGIC_KEEP: assert (!flags_out[3] && flags_out[0] == flags_in[0] && flags_out[5] == flags_in[5]) else $error("logic flags"); // R5
    end
    if (op_sel == 5'd9) begin
      AST_COM_CARRY: assert (flags_out[0] && (res ^ dst_a) == 8'hFF) else $error("com"); // R6
    end
    if (op_sel == 5'd11 || op_sel == 5'd12) begin
      AST_INCDEC_C: assert (flags_out[0] == flags_in[0] && flags_out[5] == flags_in[5]) else $error("inc/dec carry"); // R8
    end
    if (op_sel == 5'd17) begin
      AST_ASR_MSB: assert (res[7] == dst_a[7] && res[6] == dst_a[7]) else $error("asr"); // R10
    end
    if (op_sel == 5'd18) begin
      AST_SWAP_FLAGS: assert (flags_out == flags_in && res[7:4] == dst_a[3:0]) else $error("swap"); // R11
    end
  end
endmodule

bind alu8 alu8_chk u_chk (.*);

// File: tb/alu8_test.sv
module alu8_test;
  logic clk = 1'b0;
  logic [4:0] op_sel;
  logic [7:0] dst_a, src_b, res;
  logic [5:0] flags_in, flags_out;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alu8 uut (.op_sel(op_sel), .dst_a(dst_a), .src_b(src_b), .flags_in(flags_in),
            .res(res), .flags_out(flags_out));

  function automatic string tag(input int op);
    case (op)
      0, 1: return "R2";
      2, 3: return "R3";
      4, 5: return "R4";
      6, 7, 8: return "R5";
      9: return "R6";
      10: return "R7";
      11, 12: return "R8";
      13, 14, 15, 16: return "R9";
      17: return "R10";
      18: return "R11";
      default: return "R1";
    endcase
  endfunction

  function automatic int sgn(input int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  // reference model: returns {result, flags}
  function automatic logic [13:0] model(input int op, input int a, input int b, input logic [5:0] fi);
    int c = fi[0];
    int r = a, full, sr;
    logic [5:0] f = fi;
    bit nv = 1, chain = 0, keep_a = 0;
    case (op)
      0, 1: begin
        if (op == 0) c = 0;
        full = a + b + c; r = full % 256;
        sr = sgn(a) + sgn(b) + c;
        f[0] = full > 255; f[5] = (a % 16) + (b % 16) + c > 15; f[3] = (sr > 127) || (sr < -128);
      end
      2, 3, 4, 5, 10: begin
        int x = a, y = b;
        if (op == 2 || op == 4 || op == 10) c = 0;
        if (op == 10) begin x = 0; y = a; end
        full = x - y - c; r = (full + 512) % 256;
        sr = sgn(x) - sgn(y) - c;
        f[0] = full < 0; f[5] = (x % 16) - (y % 16) - c < 0; f[3] = (sr > 127) || (sr < -128);
        chain = (op == 3 || op == 5); keep_a = (op == 4 || op == 5);
      end
      6: begin r = a & b; f[3] = 0; end
      7: begin r = a | b; f[3] = 0; end
      8: begin r = a ^ b; f[3] = 0; end
      9: begin r = 255 - a; f[0] = 1; f[3] = 0; end
      11: begin r = (a + 1) % 256; f[3] = (a == 127); end
      12: begin r = (a + 255) % 256; f[3] = (a == 128); end
      13, 15: begin
        r = (a * 2) % 256 + ((op == 15) ? c : 0);
        f[0] = a >= 128; f[3] = (r >= 128) ^ f[0];
      end
      14, 16, 17: begin
        r = a / 2 + ((op == 16) ? c * 128 : (op == 17) ? (a / 128) * 128 : 0);
        f[0] = a % 2; f[3] = (r >= 128) ^ f[0];
      end
      18: begin r = (a % 16) * 16 + a / 16; nv = 0; end
      default: nv = 0;
    endcase
    if (nv) begin
      f[2] = r >= 128;
      f[1] = (r == 0) && (!chain || fi[1]);
      f[4] = f[2] ^ f[3];
    end
    if (keep_a) r = a;
    return {r[7:0], f};
  endfunction

  task automatic apply(input int op, input int a, input int b, input logic [5:0] fi);
    logic [13:0] exp;
    @(posedge clk); #2;
    op_sel = op[4:0]; dst_a = a[7:0]; src_b = b[7:0]; flags_in = fi;
    @(negedge clk);
    exp = model(op, a, b, fi);
    total++;
    if ({res, flags_out} !== exp) begin
      bad++;
      $display("FAIL %s op=%0d a=%h b=%h fi=%b: actual res=%h flags=%b expected res=%h flags=%b",
               tag(op), op, a, b, fi, res, flags_out, exp[13:6], exp[5:0]);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    op_sel = 5'd31; dst_a = 8'h5A; src_b = 8'h00; flags_in = 6'b101010;
    apply(31, 8'h5A, 0, 6'b101010);               // R1 pass-through
    apply(0, 8'h7F, 8'h01, 6'b000000);            // R2 overflow, H
    apply(0, 8'hFF, 8'h01, 6'b000000);            // R2 carry, zero
    apply(1, 8'h0F, 8'h00, 6'b000001);            // R2 half carry via carry in
    apply(2, 8'h80, 8'h01, 6'b000000);            // R3 overflow
    apply(2, 8'h10, 8'h01, 6'b000000);            // R3 half borrow
    apply(3, 8'h05, 8'h05, 6'b000000);            // R3 zero kept clear
    apply(3, 8'h05, 8'h05, 6'b000010);            // R3 zero kept set
    apply(3, 8'h06, 8'h05, 6'b000011);            // R3 zero result with borrow
    apply(5, 8'h22, 8'h21, 6'b000011);            // R4 chained compare
    apply(4, 8'h33, 8'h44, 6'b000000);            // R4 no write
    apply(6, 8'hF0, 8'h0F, 6'b101001);            // R5 zero, C/H kept
    apply(9, 8'h00, 0, 6'b000000);                // R6
    apply(10, 8'h80, 0, 6'b000000);               // R7 overflow
    apply(10, 8'h00, 0, 6'b111111);               // R7 zero, no carry
    apply(11, 8'h7F, 0, 6'b000001);               // R8
    apply(12, 8'h80, 0, 6'b100000);               // R8
    apply(12, 8'h01, 0, 6'b000001);               // R8 zero
    apply(15, 8'h80, 0, 6'b000001);               // R9 rotate in carry
    apply(16, 8'h01, 0, 6'b000000);               // R9 zero with carry out
    apply(17, 8'h81, 0, 6'b000000);               // R10
    apply(18, 8'hA5, 0, 6'b010101);               // R11
    for (int i = 0; i < 4000; i++) begin          // R12 checked on every op
      apply($urandom_range(0, 31), $urandom_range(0, 255), $urandom_range(0, 255),
            6'($urandom_range(0, 63)));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule